// File: doc/BRIEF.md
# Symmetric FIR Filter Accelerator

A streaming finite impulse response filter for linear-phase filters whose coefficients mirror about the centre. Only half of the coefficient set is stored. The delay line is folded so that the two samples sharing a coefficient are added before one multiply. For a 16-tap length, every sample pairs with its mirror. For a 15-tap length, the middle sample stands alone and is weighted by its own coefficient.

Software loads the half coefficient set and picks the length while the filter is stopped, then pulses start. Start clears the sample history. Samples stream in with a valid strobe, one per clock at most. All products for one output are formed in the same cycle. The datapath is a fixed pipeline: delay line, pre-add, multiply, adder tree, round/saturate. Each result therefore leaves a fixed number of cycles after its sample. A stop pulse returns the block to idle, where new coefficients and a new length may be loaded.

Top module: `sym_fir_accel`

## Requirements
- R1: After reset, `result_valid_o`, `busy_o` and `err_o` are all 0.
- R2: With length select `cfg_odd_i`=0 (16 taps), each output is sum over k=0..7 of c[k]·(x[n-k] + x[n-15+k]), where x[n] is the newest accepted sample and c[k] is the coefficient written at address k.
- R3: With length select 1 (15 taps), each output is sum over k=0..6 of c[k]·(x[n-k] + x[n-14+k]) plus c[7]·x[n-7]. Address 7 is the unpaired centre coefficient, and x[n-15] has no effect.
- R4: A coefficient write (`coef_we_i`, address 0..7) or a length write (`cfg_we_i`) while idle is stored and used by the next run.
- R5: A coefficient or length write while busy is ignored and sets `err_o`. `err_o` stays set until the next start.
- R6: `result_valid_o` rises exactly 5 clock cycles after the edge at which a valid sample was accepted. Samples presented while idle are not accepted, produce no result and do not enter the history.
- R7: A start pulse clears the sample history to zero, so the first outputs of a run are the convolution with zero past samples.
- R8: The full-precision sum is rounded at bit 15 (add 2^14, then arithmetic shift right by 15) and saturated to the signed 16-bit range [-32768, 32767].
- R9: A start pulse sets `busy_o` and clears `err_o` after the next edge. A stop pulse clears `busy_o`, and start wins if both arrive together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse: clear history, enter busy |
| stop_i | input | 1 | Pulse: return to idle |
| cfg_we_i | input | 1 | Length write strobe |
| cfg_odd_i | input | 1 | Length select: 0 = 16 taps, 1 = 15 taps |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_addr_i | input | 3 | Coefficient index 0..7 |
| coef_data_i | input | 16 | Signed coefficient |
| sample_valid_i | input | 1 | Sample strobe |
| sample_i | input | 16 | Signed input sample |
| result_valid_o | output | 1 | Result strobe |
| result_o | output | 16 | Signed rounded and saturated result |
| busy_o | output | 1 | Filter running |
| err_o | output | 1 | Sticky write-while-busy flag |

## Verification
Every accepted sample is due as a result exactly 5 cycles after its capture edge. The bench tags each expected value with that due cycle and compares on the falling edge of that cycle, so both a wrong value and a wrong delay are reported. The error flag and the busy flag are due one edge after their strobe and are sampled on the following falling edge. After every run the bench waits for the pipeline to drain and then confirms that no expected result is still outstanding. It also confirms that samples sent while idle never produce a result.

// File: rtl/sym_fir_pkg.sv
package sym_fir_pkg;
  typedef enum logic {MODE_EVEN = 1'b0, MODE_ODD = 1'b1} tap_mode_e;
  localparam int unsigned LAT = 5; // dl, pre-add, mult, tree, out
endpackage

// File: rtl/sym_fir_ctrl.sv
module sym_fir_ctrl
  import sym_fir_pkg::*;
#(
  parameter int unsigned HALF = 8,
  parameter int unsigned CW   = 16,
  parameter int unsigned AB   = $clog2(HALF)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     stop_i,
  input  logic                     cfg_we_i,
  input  logic                     cfg_odd_i,
  input  logic                     coef_we_i,
  input  logic [AB-1:0]            coef_addr_i,
  input  logic [CW-1:0]            coef_data_i,
  output logic                     busy_o,
  output logic                     err_o,
  output tap_mode_e                mode_o,
  output logic [HALF-1:0][CW-1:0]  coef_o
);
  logic busy_q, err_q;
  tap_mode_e mode_q;
  logic [HALF-1:0][CW-1:0] coef_q;
  logic bad_wr;

  assign bad_wr = busy_q && (cfg_we_i || coef_we_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      if (stop_i) busy_q <= 1'b0;
      if (bad_wr) err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_EVEN;
      coef_q <= '0;
    end else if (!busy_q) begin
      if (cfg_we_i) mode_q <= tap_mode_e'(cfg_odd_i);
      if (coef_we_i && (32'(coef_addr_i) < HALF)) coef_q[coef_addr_i] <= coef_data_i;
    end
  end

  assign busy_o = busy_q;
  assign err_o  = err_q;
  assign mode_o = mode_q;
  assign coef_o = coef_q;

  assert_busy_write_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && coef_we_i |=> $stable(coef_q));
  assert_busy_mode_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cfg_we_i |=> $stable(mode_q));
  assert_err_on_bad_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr && !start_i |=> err_q);
  assert_start_enters_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q && !err_q);
  assert_stop_leaves_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> !busy_q);
endmodule

// File: rtl/sym_fir_fold.sv
module sym_fir_fold
  import sym_fir_pkg::*;
#(
  parameter int unsigned TAPS = 16,
  parameter int unsigned SW   = 16,
  parameter int unsigned PW   = SW + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    fire_i,
  input  logic signed [SW-1:0]    sample_i,
  input  tap_mode_e               mode_i,
  output logic signed [PW-1:0]    pa_o [TAPS/2]
);
  localparam int unsigned HALF = TAPS / 2;

  logic signed [SW-1:0] dl_q [TAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TAPS; i++) dl_q[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < TAPS; i++) dl_q[i] <= '0;
    end else if (fire_i) begin
      dl_q[0] <= sample_i;
      for (int i = 1; i < TAPS; i++) dl_q[i] <= dl_q[i-1];
    end
  end

  for (genvar k = 0; k < HALF; k++) begin : g_pair
    logic signed [PW-1:0] mate;
    if (k == HALF - 1) begin : g_ctr
      // odd length: centre tap has no partner
      assign mate = (mode_i == MODE_ODD) ? '0 : PW'(dl_q[TAPS-1-k]);
    end else begin : g_sym
      assign mate = (mode_i == MODE_ODD) ? PW'(dl_q[TAPS-2-k]) : PW'(dl_q[TAPS-1-k]);
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pa_o[k] <= '0;
      else         pa_o[k] <= PW'(dl_q[k]) + mate;
    end
  end

  assert_clear_on_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (dl_q[0] == '0) && (dl_q[TAPS-1] == '0));
  assert_hold_when_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i && !clr_i |=> $stable(dl_q[0]));
endmodule

// File: rtl/sym_fir_mac.sv
module sym_fir_mac #(
  parameter int unsigned HALF = 8,
  parameter int unsigned SW   = 16,
  parameter int unsigned CW   = 16,
  parameter int unsigned FRAC = 15,
  parameter int unsigned PW   = SW + 1,
  parameter int unsigned MW   = PW + CW,
  parameter int unsigned AW   = MW + $clog2(HALF)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [PW-1:0]     pa_i [HALF],
  input  logic [HALF-1:0][CW-1:0]  coef_i,
  output logic signed [SW-1:0]     result_o
);
  localparam logic signed [AW-1:0] MAXV = AW'((64'sd1 <<< (SW-1)) - 64'sd1);
  localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);
  localparam logic signed [AW-1:0] HALF_LSB = AW'(64'sd1 <<< (FRAC-1));

  logic signed [MW-1:0] prod_q [HALF];
  logic signed [AW-1:0] tree_d, sum_q, rnd;

  for (genvar k = 0; k < HALF; k++) begin : g_mul
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prod_q[k] <= '0;
      else         prod_q[k] <= pa_i[k] * $signed(coef_i[k]);
    end
  end

  always_comb begin
    tree_d = '0;
    for (int k = 0; k < HALF; k++) tree_d = tree_d + AW'(prod_q[k]);
  end

  assign rnd = (sum_q + HALF_LSB) >>> FRAC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q    <= '0;
      result_o <= '0;
    end else begin
      sum_q <= tree_d;
      if (rnd > MAXV)      result_o <= SW'(MAXV);
      else if (rnd < MINV) result_o <= SW'(MINV);
      else                 result_o <= SW'(rnd);
    end
  end

  assert_sat_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_q > (MAXV <<< FRAC)) |=> (result_o == SW'(MAXV)));
  assert_sat_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_q < (MINV <<< FRAC)) |=> (result_o == SW'(MINV)));
endmodule

// File: rtl/sym_fir_accel.sv
module sym_fir_accel
  import sym_fir_pkg::*;
#(
  parameter int unsigned TAPS = 16,
  parameter int unsigned SW   = 16,
  parameter int unsigned CW   = 16,
  parameter int unsigned FRAC = 15,
  parameter int unsigned AB   = $clog2(TAPS / 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          cfg_we_i,
  input  logic          cfg_odd_i,
  input  logic          coef_we_i,
  input  logic [AB-1:0] coef_addr_i,
  input  logic [CW-1:0] coef_data_i,
  input  logic          sample_valid_i,
  input  logic [SW-1:0] sample_i,
  output logic          result_valid_o,
  output logic [SW-1:0] result_o,
  output logic          busy_o,
  output logic          err_o
);
  localparam int unsigned HALF = TAPS / 2;
  localparam int unsigned PW   = SW + 1;

  tap_mode_e mode;
  logic [HALF-1:0][CW-1:0] coef;
  logic signed [PW-1:0] pa [HALF];
  logic signed [SW-1:0] res;
  logic fire;
  logic [LAT-1:0] vld_q;

  assign fire = sample_valid_i && busy_o && !start_i;

  sym_fir_ctrl #(.HALF(HALF), .CW(CW), .AB(AB)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .stop_i, .cfg_we_i, .cfg_odd_i,
    .coef_we_i, .coef_addr_i, .coef_data_i,
    .busy_o, .err_o, .mode_o(mode), .coef_o(coef)
  );

  sym_fir_fold #(.TAPS(TAPS), .SW(SW), .PW(PW)) u_fold (
    .clk_i, .rst_ni, .clr_i(start_i), .fire_i(fire),
    .sample_i($signed(sample_i)), .mode_i(mode), .pa_o(pa)
  );

  sym_fir_mac #(.HALF(HALF), .SW(SW), .CW(CW), .FRAC(FRAC), .PW(PW)) u_mac (
    .clk_i, .rst_ni, .pa_i(pa), .coef_i(coef), .result_o(res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[LAT-2:0], fire};
  end

  assign result_valid_o = vld_q[LAT-1];
  assign result_o       = res;

  assert_fixed_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fire, 5) |-> result_valid_o);
  assert_no_spurious_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> $past(fire, 5));
  assert_idle_sample_dropped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !fire);
endmodule

// File: tb/sym_fir_accel_bench.sv
module sym_fir_accel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  localparam int LATC = 5;
  localparam logic signed [15:0] VEC [NV] = '{
    16'sd1000, -16'sd2000, 16'sd32767, -16'sd32768, 16'sd7, 16'sd0, 16'sd12345, -16'sd54,
    16'sd300, 16'sd20000, -16'sd15000, 16'sd1, -16'sd1, 16'sd4096, -16'sd8191, 16'sd2500};
  localparam int CSET [8] = '{120, -340, 910, -1800, 3300, -5200, 9100, 16000};

  logic clk_i = 0, rst_ni = 0;
  logic start_i = 0, stop_i = 0, cfg_we_i = 0, cfg_odd_i = 0, coef_we_i = 0;
  logic [2:0] coef_addr_i = 0;
  logic [15:0] coef_data_i = 0, sample_i = 0;
  logic sample_valid_i = 0;
  logic result_valid_o, busy_o, err_o;
  logic [15:0] result_o;

  sym_fir_accel u_sym_fir_accel (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_err = 0, cyc = 0;
  int exp_q[$], due_q[$];
  string tag_q[$];
  int hist[16];
  int cm[8];
  bit m_odd = 0, tb_busy = 0, done = 0;
  string cur_tag = "R2";

  always @(posedge clk_i) cyc++;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && result_valid_o) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R6 unexpected result actual=%0d expected=none", $signed(result_o));
      end else begin
        automatic int e = exp_q.pop_front();
        automatic int d = due_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, $signed(result_o), e);
        check("R6 latency", cyc, d);
      end
    end
  end

  function automatic int model_push(input int s);
    longint acc = 0;
    longint y;
    for (int i = 15; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = s;
    for (int k = 0; k < 8; k++) begin
      if (m_odd) begin
        if (k == 7) acc += longint'(cm[k]) * hist[7];
        else        acc += longint'(cm[k]) * (hist[k] + hist[14-k]);
      end else begin
        acc += longint'(cm[k]) * (hist[k] + hist[15-k]);
      end
    end
    y = (acc + 16384) >>> 15;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return int'(y);
  endfunction

  task automatic send(input int s);
    @(negedge clk_i);
    sample_valid_i = 1;
    sample_i = 16'(s);
    if (tb_busy) begin
      exp_q.push_back(model_push(s));
      due_q.push_back(cyc + LATC);
      tag_q.push_back(cur_tag);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk_i);
    sample_valid_i = 0;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_coef(input int a, input int v, input bit accepted);
    @(negedge clk_i);
    coef_we_i = 1; coef_addr_i = 3'(a); coef_data_i = 16'(v);
    @(negedge clk_i);
    coef_we_i = 0;
    if (accepted) cm[a] = v;
  endtask

  task automatic wr_cfg(input bit odd, input bit accepted);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_odd_i = odd;
    @(negedge clk_i);
    cfg_we_i = 0;
    if (accepted) m_odd = odd;
  endtask

  task automatic go();
    @(negedge clk_i);
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    tb_busy = 1;
    foreach (hist[i]) hist[i] = 0;
  endtask

  task automatic halt();
    @(negedge clk_i);
    stop_i = 1;
    tb_busy = 0;
    @(negedge clk_i);
    stop_i = 0;
  endtask

  task automatic drain(input string req);
    idle(LATC + 3);
    check(req, exp_q.size(), 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 valid", result_valid_o, 0);
    check("R1 busy", busy_o, 0);
    check("R1 err", err_o, 0);
    rst_ni = 1;

    // R4: idle loads, then even run over the vector table
    for (int k = 0; k < 8; k++) wr_coef(k, CSET[k], 1);
    wr_cfg(0, 1);
    go();
    check("R9 busy after start", busy_o, 1);
    cur_tag = "R2 even";
    for (int i = 0; i < NV; i++) send(VEC[i]);
    for (int i = 0; i < NV; i++) send(VEC[NV-1-i]);
    drain("R2 drain");
    halt();
    check("R9 idle after stop", busy_o, 0);

    // R3: odd length, gapped input
    wr_cfg(1, 1);
    go();
    cur_tag = "R3 odd";
    for (int i = 0; i < NV; i++) begin
      send(VEC[i]);
      if (i % 3 == 0) idle(1);
    end
    for (int i = 0; i < NV; i++) send(VEC[(i * 5) % NV]);
    drain("R3 drain");

    // R5: writes while busy ignored, flag sticky
    wr_coef(0, 31000, 0);
    check("R5 err after coef write", err_o, 1);
    wr_cfg(0, 0);
    check("R5 err sticky", err_o, 1);
    cur_tag = "R5 old coefs/mode kept";
    for (int i = 0; i < NV; i++) send(VEC[i]);
    drain("R5 drain");
    halt();

    // R6: idle samples dropped; R7: restart with zero history
    for (int i = 0; i < 4; i++) send(16'sd20000);
    idle(LATC + 3);
    check("R6 idle no output", exp_q.size(), 0);
    go();
    check("R9 err cleared by start", err_o, 0);
    cur_tag = "R7 zero history";
    for (int i = 0; i < 4; i++) send(VEC[i]);
    drain("R7 drain");
    halt();

    // R8: rounding half up and saturation
    wr_cfg(0, 1);
    wr_coef(0, 16384, 1);
    for (int k = 1; k < 8; k++) wr_coef(k, 0, 1);
    go();
    cur_tag = "R8 round";
    send(1); send(-1); send(3); send(-3);
    drain("R8 round drain");
    halt();
    for (int k = 0; k < 8; k++) wr_coef(k, 32767, 1);
    go();
    cur_tag = "R8 saturate";
    for (int i = 0; i < 16; i++) send(32767);
    for (int i = 0; i < 16; i++) send(-32768);
    drain("R8 sat drain");
    halt();

    summary();
  end
endmodule